// File: doc/BRIEF.md
# Indexed Colour Lookup Table with Queued Host Loading

This block turns an 8-bit pixel index into an 8-bit red, green and blue triple through a 256-entry table. The display path presents one index per clock and receives the matching colour one clock later from a registered output stage.

The host updates the table by pushing (index, colour word) pairs into a four-slot queue. It can read back how many slots are free, and it must wait while that count is zero. Queued updates reach the table only while the drain-enable input is high. The display controller raises that input during blanking, so updates never disturb pixels being shown. A push that arrives while the queue is full is discarded and raises a sticky overflow flag. On reset every entry is set to a grey ramp.

Top module: `cmap_palette`

## Requirements
- R1: After reset, host_free_slots is 4, host_overflow is 0, and entry i holds i in its red, green and blue fields.
- R2: pix_red, pix_green and pix_blue show the entry addressed by pix_idx at the clock edge after the index is presented.
- R3: A host colour word carries red in bits 31:24, green in bits 23:16 and blue in bits 15:8. Bits 7:0 have no effect on the table.
- R4: Each accepted host write lowers host_free_slots by one, starting from the edge that accepts it.
- R5: While drain_en is low, queued writes stay queued: the table is unchanged and host_free_slots does not rise.
- R6: While drain_en is high, one queued write per clock is committed, oldest first. Of two writes to the same index, the later one wins.
- R7: A host write made while host_free_slots is 0 is discarded and sets host_overflow. The discarded write never reaches the table.
- R8: If a write is accepted in the same clock as a drain, host_free_slots stays unchanged.
- R9: Once set, host_overflow stays set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both the host side and the pixel side |
| rst_n | input | 1 | Synchronous reset, active low |
| host_wr_en | input | 1 | Host write strobe, one write per cycle |
| host_wr_idx | input | 8 | Table entry the write targets |
| host_wr_word | input | 32 | Packed colour word |
| host_free_slots | output | 3 | Number of free queue slots |
| host_overflow | output | 1 | Sticky flag: a write was discarded |
| drain_en | input | 1 | High when queued writes may be committed (blanking) |
| pix_idx | input | 8 | Pixel index |
| pix_red | output | 8 | Red value, one cycle after the index |
| pix_green | output | 8 | Green value, one cycle after the index |
| pix_blue | output | 8 | Blue value, one cycle after the index |

## Verification
A wrong queue pointer or count shows up at once on host_free_slots, on the edge after the push or drain that upsets it. It shows up later as the wrong colour, or a colour in the wrong order, when the affected entry is read one cycle after its index is presented. A commit made while drain_en is low appears as a changed colour on the very next read of that entry. A lost or spurious overflow appears on host_overflow one edge after a write to a full queue, and a flag that clears itself appears on any later sample.

// File: rtl/cmap_pkg.sv
// Package: shared widths and record types for the colour lookup block.
// Assumes eight-bit channels and an eight-bit index throughout.
package cmap_pkg;
    localparam int IDX_W   = 8;
    localparam int CH_W    = 8;
    localparam int ENTRIES = 1 << IDX_W;
    localparam int WORD_W  = 32;

    typedef struct packed {
        logic [CH_W-1:0] r;
        logic [CH_W-1:0] g;
        logic [CH_W-1:0] b;
    } rgb_t;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        rgb_t             rgb;
    } cmap_upd_t;
endpackage

// File: rtl/cmap_wr_fifo.sv
// Module: cmap_wr_fifo
// Small queue of pending table updates. A push is accepted only when the
// queue is not full; one entry leaves per clock while drain_en is high.
// Assumes DEPTH is a power of two, so the pointers wrap on their own.
module cmap_wr_fifo
    import cmap_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_req,
    input  cmap_upd_t        push_data,
    input  logic             drain_en,
    output logic             pop_valid,
    output cmap_upd_t        pop_data,
    output logic             push_drop,
    output logic [CNT_W-1:0] free_cnt
);
    cmap_upd_t        slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] used;
    logic             full, push_ok;

    assign full      = (used == CNT_W'(DEPTH));
    assign push_ok   = push_req && !full;
    assign push_drop = push_req && full;
    assign pop_valid = drain_en && (used != '0);
    assign pop_data  = slots[rd_ptr];
    assign free_cnt  = CNT_W'(DEPTH) - used;

    // Store an accepted push at the write pointer.
    always_ff @(posedge clk) begin
        if (push_ok) slots[wr_ptr] <= push_data;
    end

    // Advance the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            used   <= '0;
        end else begin
            if (push_ok)   wr_ptr <= wr_ptr + 1'b1;
            if (pop_valid) rd_ptr <= rd_ptr + 1'b1;
            used <= used + CNT_W'(push_ok) - CNT_W'(pop_valid);
        end
    end

    // R4: the free count never exceeds the depth.
    a_r4_free_bound: assert property (@(posedge clk) disable iff (!rst_n)
        free_cnt <= CNT_W'(DEPTH));
    // R5: without drain_en the free count never rises.
    a_r5_hold_without_drain: assert property (@(posedge clk) disable iff (!rst_n)
        !drain_en |=> free_cnt <= $past(free_cnt));
    // R7: a push into a full queue that is not draining leaves it full.
    a_r7_full_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && free_cnt == '0 && !drain_en) |=> free_cnt == '0);
endmodule

// File: rtl/cmap_table.sv
// Module: cmap_table
// The colour table itself. It has one write port, fed from the queue, and one
// read port with a registered output for the pixel path. Reset fills every
// entry with the grey ramp. A read and a write to the same entry in one clock
// return the old value.
module cmap_table
    import cmap_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  rgb_t             wr_rgb,
    input  logic [IDX_W-1:0] rd_idx,
    output rgb_t             rd_rgb
);
    rgb_t mem [ENTRIES];

    // Load the grey ramp on reset, otherwise commit the drained update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                mem[i] <= '{r: CH_W'(i), g: CH_W'(i), b: CH_W'(i)};
            end
        end else if (wr_en) begin
            mem[wr_idx] <= wr_rgb;
        end
    end

    // Register the pixel-side read.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_rgb <= '0;
        else        rd_rgb <= mem[rd_idx];
    end
endmodule

// File: rtl/cmap_palette.sv
// Module: cmap_palette (top)
// Host writes are unpacked and queued. Queued writes are committed to the table
// only while drain_en is high. The pixel path reads the table every clock with
// one cycle of latency. A write to a full queue is dropped and latches
// host_overflow until reset.
module cmap_palette
    import cmap_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    localparam int FREE_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr_en,
    input  logic [7:0]        host_wr_idx,
    input  logic [31:0]       host_wr_word,
    output logic [FREE_W-1:0] host_free_slots,
    output logic              host_overflow,
    input  logic              drain_en,
    input  logic [7:0]        pix_idx,
    output logic [7:0]        pix_red,
    output logic [7:0]        pix_green,
    output logic [7:0]        pix_blue
);
    cmap_upd_t push_rec, pop_rec;
    logic      pop_valid, push_drop;
    rgb_t      pix_rgb;
    logic      unused_low_byte;

    // Unpack the host word: red, green and blue in the upper three bytes.
    always_comb begin
        push_rec.idx   = host_wr_idx;
        push_rec.rgb.r = host_wr_word[31:24];
        push_rec.rgb.g = host_wr_word[23:16];
        push_rec.rgb.b = host_wr_word[15:8];
    end
    assign unused_low_byte = ^host_wr_word[7:0];

    cmap_wr_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_req  (host_wr_en),
        .push_data (push_rec),
        .drain_en  (drain_en),
        .pop_valid (pop_valid),
        .pop_data  (pop_rec),
        .push_drop (push_drop),
        .free_cnt  (host_free_slots)
    );

    cmap_table u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (pop_valid),
        .wr_idx (pop_rec.idx),
        .wr_rgb (pop_rec.rgb),
        .rd_idx (pix_idx),
        .rd_rgb (pix_rgb)
    );

    // Latch the overflow flag on any dropped write.
    always_ff @(posedge clk) begin
        if (!rst_n)         host_overflow <= 1'b0;
        else if (push_drop) host_overflow <= 1'b1;
    end

    assign pix_red   = pix_rgb.r;
    assign pix_green = pix_rgb.g;
    assign pix_blue  = pix_rgb.b;

    // R9: the overflow flag never clears on its own.
    a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        host_overflow |=> host_overflow);
    // R7: a write seen with zero free slots raises the flag.
    a_r7_overflow_on_full: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_en && host_free_slots == '0) |=> host_overflow);
endmodule

// File: tb/tb_cmap_palette.sv
module tb_cmap_palette;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr_en = 1'b0;
    logic [7:0]  host_wr_idx = '0;
    logic [31:0] host_wr_word = '0;
    logic [2:0]  host_free_slots;
    logic        host_overflow;
    logic        drain_en = 1'b0;
    logic [7:0]  pix_idx = '0;
    logic [7:0]  pix_red, pix_green, pix_blue;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    cmap_palette dut (
        .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_wr_idx(host_wr_idx),
        .host_wr_word(host_wr_word), .host_free_slots(host_free_slots),
        .host_overflow(host_overflow), .drain_en(drain_en), .pix_idx(pix_idx),
        .pix_red(pix_red), .pix_green(pix_green), .pix_blue(pix_blue)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic read_chk(input logic [7:0] idx, input logic [23:0] exp, input string req);
        logic [23:0] got;
        @(negedge clk) pix_idx = idx;
        @(negedge clk);
        got = {pix_red, pix_green, pix_blue};
        chk(got == exp, req, got, exp);
    endtask

    task automatic push(input logic [7:0] idx, input logic [31:0] word);
        @(negedge clk);
        host_wr_en = 1'b1; host_wr_idx = idx; host_wr_word = word;
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    task automatic drain(input int n);
        @(negedge clk) drain_en = 1'b1;
        repeat (n) @(negedge clk);
        drain_en = 1'b0;
    endtask

    // R1, R2: reset state and grey ramp read with one cycle of latency.
    task automatic t_reset();
        chk(host_free_slots == 3'd4, "R1 free", host_free_slots, 4);
        chk(host_overflow == 1'b0, "R1 ovf", host_overflow, 0);
        read_chk(8'd0,   24'h000000, "R1 grey0");
        read_chk(8'd5,   24'h050505, "R2 grey5");
        read_chk(8'd255, 24'hFFFFFF, "R1 grey255");
    endtask

    // R4, R5, R7: fill without draining, then overflow.
    task automatic t_fill_and_overflow();
        push(8'd1, 32'h11223344);
        chk(host_free_slots == 3'd3, "R4 free3", host_free_slots, 3);
        push(8'd2, 32'hA0B0C0FF);
        push(8'd3, 32'h0F1E2D5A);
        chk(host_free_slots == 3'd1, "R4 free1", host_free_slots, 1);
        repeat (3) @(negedge clk);
        chk(host_free_slots == 3'd1, "R5 hold", host_free_slots, 1);
        read_chk(8'd1, 24'h010101, "R5 not committed");
        push(8'd4, 32'hFFEEDD01);
        chk(host_free_slots == 3'd0, "R4 free0", host_free_slots, 0);
        chk(host_overflow == 1'b0, "R7 no ovf yet", host_overflow, 0);
        push(8'd5, 32'h12345678);
        chk(host_overflow == 1'b1, "R7 ovf set", host_overflow, 1);
        chk(host_free_slots == 3'd0, "R7 still full", host_free_slots, 0);
    endtask

    // R6, R3, R7, R9: one commit per clock, then check contents.
    task automatic t_drain();
        drain(1);
        chk(host_free_slots == 3'd1, "R6 one per clock", host_free_slots, 1);
        drain(3);
        chk(host_free_slots == 3'd4, "R6 empty", host_free_slots, 4);
        read_chk(8'd1, 24'h112233, "R3 idx1");
        read_chk(8'd2, 24'hA0B0C0, "R3 idx2");
        read_chk(8'd3, 24'h0F1E2D, "R3 idx3");
        read_chk(8'd4, 24'hFFEEDD, "R3 idx4");
        read_chk(8'd5, 24'h050505, "R7 dropped write absent");
        chk(host_overflow == 1'b1, "R9 sticky", host_overflow, 1);
    endtask

    // R6: later write to the same index wins.
    task automatic t_order();
        push(8'd10, 32'h01020300);
        push(8'd10, 32'h0A0B0C00);
        drain(2);
        read_chk(8'd10, 24'h0A0B0C, "R6 order");
    endtask

    // R8: push and drain in the same clock.
    task automatic t_concurrent();
        push(8'd20, 32'h20212200);
        chk(host_free_slots == 3'd3, "R4 free3b", host_free_slots, 3);
        @(negedge clk);
        host_wr_en = 1'b1; host_wr_idx = 8'd21; host_wr_word = 32'h30313200; drain_en = 1'b1;
        @(negedge clk);
        host_wr_en = 1'b0;
        chk(host_free_slots == 3'd3, "R8 balanced", host_free_slots, 3);
        @(negedge clk);
        drain_en = 1'b0;
        chk(host_free_slots == 3'd4, "R6 drained", host_free_slots, 4);
        read_chk(8'd20, 24'h202122, "R8 idx20");
        read_chk(8'd21, 24'h303132, "R8 idx21");
        chk(host_overflow == 1'b1, "R9 still set", host_overflow, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill_and_overflow();
        t_drain();
        t_order();
        t_concurrent();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule